// File: doc/BRIEF.md
# DMA Instruction Stream Decoder

This block watches a stream of 32-bit words taken from a DMA instruction queue and splits it back into instructions. The first word of each instruction carries a 4-bit opcode, a field of flag bits and a 12-bit byte count. Depending on the opcode, the instruction also has zero to three argument words after it. The decoder keeps track of where each instruction ends, so an argument word is never decoded as an opcode, even when its top nibble looks like a valid opcode.

For every accepted word the block produces one registered output record one cycle later. For an opcode word the record holds the opcode class, the instruction length, the count, the decoded flags, the undecoded spare bits and an invalid-opcode strobe. For an argument word the record holds the class and length of the instruction that owns it, plus the argument's position inside that instruction. A synchronous restart input realigns the decoder so that it expects an opcode next. The opcode code values are parameters.

Top module: `dma_instr_decoder`

## Requirements
- R1: After reset, `o_valid` is 0 and all other outputs are 0. The first word accepted after reset is decoded as an opcode.
- R2: The opcode is word bits 31:28. With the default codes, the class output is: 0x8 gives 0 (sync), 0x1 gives 1 (write), 0x5 gives 2 (writec), 0x9 gives 3 (read), 0xA gives 4 (readc), 0x7 gives 5 (jump), 0x2 gives 6 (skip), 0xB gives 7 (masked register write), 0xC gives 8 (masked counter write) and 0xD gives 9 (counter-register write).
- R3: For an opcode word, `o_count` equals word bits 11:0. For an argument word it is 0.
- R4: For an opcode word the flag outputs show these word bits: `o_sol` bit 27, `o_eol` bit 26, `o_irq2` bit 25, `o_irq1` bit 24, `o_cnt1` bit 17, `o_cnt0` bit 16, `o_resync` bit 15. `o_spare` is {bits 23:18, bits 14:12}. All of these outputs are 0 for an argument word.
- R5: Instruction length, shown on `o_len`: write and jump are 2 words, the two masked writes are 3 words, the counter-register write is 4 words, and every other opcode is 1 word.
- R6: The N-1 words after an N-word opcode are reported with `o_is_op`=0, `o_arg_idx` counting 1 to N-1, and the class and length of their instruction. The word after the last argument is decoded as an opcode.
- R7: An opcode code outside the recognised set gives class 15 and length 1, and raises `o_invalid` for exactly that output cycle. `o_invalid` is never raised for an argument word.
- R8: A cycle with `i_valid` low gives `o_valid`=0 and all other outputs 0 one cycle later, and does not advance the position within an instruction.
- R9: `i_restart` together with a valid word makes that word an opcode. `i_restart` alone makes the next valid word an opcode. Restart takes priority over any pending arguments.
- R10: The output record for a word sampled at a clock edge appears after the next edge, a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_restart | input | 1 | Realign: expect an opcode word |
| i_valid | input | 1 | `i_word` carries a stream word this cycle |
| i_word | input | 32 | Stream word |
| o_valid | output | 1 | Output record is valid |
| o_is_op | output | 1 | Record describes an opcode word |
| o_class | output | 4 | Opcode class (15 = invalid) |
| o_len | output | 3 | Length in words of the owning instruction |
| o_arg_idx | output | 2 | Argument position, 0 for an opcode word |
| o_count | output | 12 | Byte count of an opcode word |
| o_sol | output | 1 | Start-of-line flag |
| o_eol | output | 1 | End-of-line flag |
| o_irq2 | output | 1 | Second interrupt flag |
| o_irq1 | output | 1 | First interrupt flag |
| o_cnt1 | output | 1 | Counter flag 1 |
| o_cnt0 | output | 1 | Counter flag 0 |
| o_resync | output | 1 | Resync flag |
| o_spare | output | 9 | Undecoded flag bits |
| o_invalid | output | 1 | Strobe for an unrecognised opcode |

## Verification
The bench sweeps all sixteen opcode codes. It follows each one with argument words whose top nibble is a valid write code, so a decoder that resyncs on every word would decode those arguments as opcodes and report the wrong class and index. It walks a single set bit across every flag position, which exposes a swapped or missing bit mapping. It inserts idle gaps in the middle of an instruction; a tracker that counted idle cycles would then lose its place. It also applies restart in the middle of an instruction, both with a word and without one; a decoder that ignored restart would go on reporting arguments where an opcode is expected.

// File: rtl/dma_isd_pkg.sv
package dma_isd_pkg;

    localparam int WORD_W      = 32;
    localparam int OPC_W       = 4;
    localparam int OPC_LSB     = WORD_W - OPC_W;
    localparam int CNT_W       = 12;
    localparam int MAX_LEN     = 4;
    localparam int LEN_W       = $clog2(MAX_LEN + 1);
    localparam int IDX_W       = $clog2(MAX_LEN);
    localparam int NUM_CLASSES = 10;
    localparam int SPARE_W     = 9;

    localparam int POS_SOL    = 27;
    localparam int POS_EOL    = 26;
    localparam int POS_IRQ2   = 25;
    localparam int POS_IRQ1   = 24;
    localparam int POS_CNT1   = 17;
    localparam int POS_CNT0   = 16;
    localparam int POS_RESYNC = 15;

    typedef enum logic [3:0] {
        CL_SYNC    = 4'd0,
        CL_WRITE   = 4'd1,
        CL_WRITEC  = 4'd2,
        CL_READ    = 4'd3,
        CL_READC   = 4'd4,
        CL_JUMP    = 4'd5,
        CL_SKIP    = 4'd6,
        CL_WRRM    = 4'd7,
        CL_WRCM    = 4'd8,
        CL_WRCR    = 4'd9,
        CL_INVALID = 4'd15
    } op_class_e;

    typedef struct packed {
        logic               sol;
        logic               eol;
        logic               irq2;
        logic               irq1;
        logic               cnt1;
        logic               cnt0;
        logic               resync;
        logic [SPARE_W-1:0] spare;
    } flag_t;

    typedef struct packed {
        op_class_e          cls;
        logic [LEN_W-1:0]   len;
        logic               bad;
    } op_info_t;

    typedef struct packed {
        logic               valid;
        logic               is_op;
        op_class_e          cls;
        logic [LEN_W-1:0]   len;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   count;
        flag_t              flags;
        logic               invalid;
    } out_rec_t;

    function automatic logic [LEN_W-1:0] class_len(input op_class_e c);
        case (c)
            CL_WRITE, CL_JUMP: class_len = LEN_W'(2);
            CL_WRRM, CL_WRCM:  class_len = LEN_W'(3);
            CL_WRCR:           class_len = LEN_W'(4);
            default:           class_len = LEN_W'(1);
        endcase
    endfunction

endpackage

// File: rtl/isd_opcode_map.sv
module isd_opcode_map
    import dma_isd_pkg::*;
#(
    parameter logic [3:0] CODE_SYNC   = 4'h8,
    parameter logic [3:0] CODE_WRITE  = 4'h1,
    parameter logic [3:0] CODE_WRITEC = 4'h5,
    parameter logic [3:0] CODE_READ   = 4'h9,
    parameter logic [3:0] CODE_READC  = 4'hA,
    parameter logic [3:0] CODE_JUMP   = 4'h7,
    parameter logic [3:0] CODE_SKIP   = 4'h2,
    parameter logic [3:0] CODE_WRRM   = 4'hB,
    parameter logic [3:0] CODE_WRCM   = 4'hC,
    parameter logic [3:0] CODE_WRCR   = 4'hD
) (
    input  logic [OPC_W-1:0] code,
    output op_info_t         info
);
    // table index equals the class encoding
    localparam logic [OPC_W-1:0] CODE_TAB [NUM_CLASSES] = '{
        CODE_SYNC, CODE_WRITE, CODE_WRITEC, CODE_READ, CODE_READC,
        CODE_JUMP, CODE_SKIP, CODE_WRRM, CODE_WRCM, CODE_WRCR
    };

    logic [NUM_CLASSES-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NUM_CLASSES; g++) begin : g_match
            assign hit[g] = (code == CODE_TAB[g]);
        end
    endgenerate

    op_class_e cls;

    always_comb begin
        cls = CL_INVALID;
        for (int k = NUM_CLASSES - 1; k >= 0; k--) begin
            if (hit[k]) cls = op_class_e'(4'(k));
        end
    end

    always_comb begin
        info.cls = cls;
        info.len = class_len(cls);
        info.bad = (hit == '0);
    end

endmodule

// File: rtl/isd_flag_split.sv
module isd_flag_split
    import dma_isd_pkg::*;
(
    input  logic [OPC_LSB-1:0] body,
    output flag_t              flags,
    output logic [CNT_W-1:0]   count
);
    always_comb begin
        flags.sol    = body[POS_SOL];
        flags.eol    = body[POS_EOL];
        flags.irq2   = body[POS_IRQ2];
        flags.irq1   = body[POS_IRQ1];
        flags.cnt1   = body[POS_CNT1];
        flags.cnt0   = body[POS_CNT0];
        flags.resync = body[POS_RESYNC];
        flags.spare  = {body[23:18], body[14:12]};
        count        = body[CNT_W-1:0];
    end
endmodule

// File: rtl/isd_frame_tracker.sv
module isd_frame_tracker
    import dma_isd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             valid,
    input  op_info_t         word_info,
    output logic             at_op,
    output logic [IDX_W-1:0] arg_idx,
    output op_class_e        owner_cls,
    output logic [LEN_W-1:0] owner_len
);
    logic [LEN_W-1:0] remaining;
    logic [IDX_W-1:0] next_idx;
    op_class_e        cur_cls;
    logic [LEN_W-1:0] cur_len;

    assign at_op     = restart || (remaining == '0);
    assign arg_idx   = at_op ? '0 : next_idx;
    assign owner_cls = cur_cls;
    assign owner_len = cur_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            next_idx  <= IDX_W'(1);
            cur_cls   <= CL_SYNC;
            cur_len   <= LEN_W'(1);
        end else if (valid) begin
            if (at_op) begin
                remaining <= word_info.len - LEN_W'(1);
                next_idx  <= IDX_W'(1);
                cur_cls   <= word_info.cls;
                cur_len   <= word_info.len;
            end else begin
                remaining <= remaining - LEN_W'(1);
                next_idx  <= next_idx + IDX_W'(1);
            end
        end else if (restart) begin
            remaining <= '0;
        end
    end
endmodule

// File: rtl/dma_instr_decoder.sv
module dma_instr_decoder
    import dma_isd_pkg::*;
#(
    parameter logic [3:0] CODE_SYNC   = 4'h8,
    parameter logic [3:0] CODE_WRITE  = 4'h1,
    parameter logic [3:0] CODE_WRITEC = 4'h5,
    parameter logic [3:0] CODE_READ   = 4'h9,
    parameter logic [3:0] CODE_READC  = 4'hA,
    parameter logic [3:0] CODE_JUMP   = 4'h7,
    parameter logic [3:0] CODE_SKIP   = 4'h2,
    parameter logic [3:0] CODE_WRRM   = 4'hB,
    parameter logic [3:0] CODE_WRCM   = 4'hC,
    parameter logic [3:0] CODE_WRCR   = 4'hD
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        i_restart,
    input  logic        i_valid,
    input  logic [31:0] i_word,
    output logic        o_valid,
    output logic        o_is_op,
    output logic [3:0]  o_class,
    output logic [2:0]  o_len,
    output logic [1:0]  o_arg_idx,
    output logic [11:0] o_count,
    output logic        o_sol,
    output logic        o_eol,
    output logic        o_irq2,
    output logic        o_irq1,
    output logic        o_cnt1,
    output logic        o_cnt0,
    output logic        o_resync,
    output logic [8:0]  o_spare,
    output logic        o_invalid
);
    op_info_t         word_info;
    flag_t            word_flags;
    logic [CNT_W-1:0] word_count;
    logic             at_op;
    logic [IDX_W-1:0] arg_idx;
    op_class_e        owner_cls;
    logic [LEN_W-1:0] owner_len;
    out_rec_t         rec_d, rec_q;

    isd_opcode_map #(
        .CODE_SYNC(CODE_SYNC), .CODE_WRITE(CODE_WRITE), .CODE_WRITEC(CODE_WRITEC),
        .CODE_READ(CODE_READ), .CODE_READC(CODE_READC), .CODE_JUMP(CODE_JUMP),
        .CODE_SKIP(CODE_SKIP), .CODE_WRRM(CODE_WRRM), .CODE_WRCM(CODE_WRCM),
        .CODE_WRCR(CODE_WRCR)
    ) u_map (
        .code (i_word[WORD_W-1:OPC_LSB]),
        .info (word_info)
    );

    isd_flag_split u_flags (
        .body  (i_word[OPC_LSB-1:0]),
        .flags (word_flags),
        .count (word_count)
    );

    isd_frame_tracker u_track (
        .clk       (clk),
        .rst       (rst),
        .restart   (i_restart),
        .valid     (i_valid),
        .word_info (word_info),
        .at_op     (at_op),
        .arg_idx   (arg_idx),
        .owner_cls (owner_cls),
        .owner_len (owner_len)
    );

    always_comb begin
        rec_d = '0;
        if (i_valid) begin
            rec_d.valid = 1'b1;
            if (at_op) begin
                rec_d.is_op   = 1'b1;
                rec_d.cls     = word_info.cls;
                rec_d.len     = word_info.len;
                rec_d.count   = word_count;
                rec_d.flags   = word_flags;
                rec_d.invalid = word_info.bad;
            end else begin
                rec_d.cls = owner_cls;
                rec_d.len = owner_len;
                rec_d.idx = arg_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rec_q <= '0;
        else     rec_q <= rec_d;
    end

    assign o_valid   = rec_q.valid;
    assign o_is_op   = rec_q.is_op;
    assign o_class   = rec_q.cls;
    assign o_len     = rec_q.len;
    assign o_arg_idx = rec_q.idx;
    assign o_count   = rec_q.count;
    assign o_sol     = rec_q.flags.sol;
    assign o_eol     = rec_q.flags.eol;
    assign o_irq2    = rec_q.flags.irq2;
    assign o_irq1    = rec_q.flags.irq1;
    assign o_cnt1    = rec_q.flags.cnt1;
    assign o_cnt0    = rec_q.flags.cnt0;
    assign o_resync  = rec_q.flags.resync;
    assign o_spare   = rec_q.flags.spare;
    assign o_invalid = rec_q.invalid;

endmodule

// File: rtl/isd_checker.sv
module isd_checker (
    input logic        clk,
    input logic        rst,
    input logic        i_restart,
    input logic        i_valid,
    input logic        o_valid,
    input logic        o_is_op,
    input logic [3:0]  o_class,
    input logic [2:0]  o_len,
    input logic [1:0]  o_arg_idx,
    input logic [11:0] o_count,
    input logic        o_invalid
);
    logic [1:0] last_idx;

    always_ff @(posedge clk) begin
        if (rst) last_idx <= '0;
        else if (o_valid) last_idx <= o_is_op ? 2'd0 : o_arg_idx;
    end

    AST_ARG_IDX_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_is_op) |-> (o_arg_idx != 2'd0));   // R6
    AST_ARG_IDX_SEQ: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_is_op) |-> (last_idx == o_arg_idx - 2'd1));   // R6
    AST_ARG_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_is_op) |-> ({1'b0, o_arg_idx} < o_len));   // R5
    AST_ARG_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_is_op) |-> (o_count == 12'd0 && !o_invalid));   // R3
    AST_INVALID_SHAPE: assert property (@(posedge clk) disable iff (rst)
        o_invalid |-> (o_valid && o_is_op && o_len == 3'd1 && o_class == 4'd15));   // R7
    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !i_valid |=> !o_valid);   // R8
    AST_RESTART_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (i_restart && i_valid) |=> o_is_op);   // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        i_valid |=> o_valid);   // R10
endmodule

bind dma_instr_decoder isd_checker u_isd_checker (
    .clk(clk), .rst(rst), .i_restart(i_restart), .i_valid(i_valid),
    .o_valid(o_valid), .o_is_op(o_is_op), .o_class(o_class), .o_len(o_len),
    .o_arg_idx(o_arg_idx), .o_count(o_count), .o_invalid(o_invalid)
);

// File: tb/tb_dma_instr_decoder.sv
module tb_dma_instr_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        i_restart = 1'b0;
    logic        i_valid = 1'b0;
    logic [31:0] i_word = '0;
    logic        o_valid, o_is_op, o_invalid;
    logic [3:0]  o_class;
    logic [2:0]  o_len;
    logic [1:0]  o_arg_idx;
    logic [11:0] o_count;
    logic        o_sol, o_eol, o_irq2, o_irq1, o_cnt1, o_cnt0, o_resync;
    logic [8:0]  o_spare;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int        m_rem = 0;
    int        m_idx = 1;
    logic [3:0] m_cls = 4'd0;
    logic [2:0] m_len = 3'd1;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_instr_decoder dut (
        .clk(clk), .rst(rst), .i_restart(i_restart), .i_valid(i_valid), .i_word(i_word),
        .o_valid(o_valid), .o_is_op(o_is_op), .o_class(o_class), .o_len(o_len),
        .o_arg_idx(o_arg_idx), .o_count(o_count), .o_sol(o_sol), .o_eol(o_eol),
        .o_irq2(o_irq2), .o_irq1(o_irq1), .o_cnt1(o_cnt1), .o_cnt0(o_cnt0),
        .o_resync(o_resync), .o_spare(o_spare), .o_invalid(o_invalid)
    );

    function automatic logic [3:0] exp_cls(input logic [3:0] c);
        case (c)
            4'h8: return 4'd0;  4'h1: return 4'd1;  4'h5: return 4'd2;
            4'h9: return 4'd3;  4'hA: return 4'd4;  4'h7: return 4'd5;
            4'h2: return 4'd6;  4'hB: return 4'd7;  4'hC: return 4'd8;
            4'hD: return 4'd9;  default: return 4'd15;
        endcase
    endfunction

    function automatic logic [2:0] exp_len(input logic [3:0] cls);
        case (cls)
            4'd1, 4'd5: return 3'd2;
            4'd7, 4'd8: return 3'd3;
            4'd9:       return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    function automatic logic [39:0] actual();
        return {o_valid, o_is_op, o_class, o_len, o_arg_idx, o_count,
                o_sol, o_eol, o_irq2, o_irq1, o_cnt1, o_cnt0, o_resync,
                o_spare, o_invalid};
    endfunction

    task automatic compare(input logic [39:0] exp, input string req);
        logic [39:0] act;
        act = actual();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one word, wait for its record, check it against the model
    task automatic send(input logic [31:0] w, input bit rs, input string req);
        logic [39:0] exp;
        logic [3:0]  c;
        logic [2:0]  l;
        if (rs || m_rem == 0) begin
            c = exp_cls(w[31:28]);
            l = exp_len(c);
            exp = {1'b1, 1'b1, c, l, 2'd0, w[11:0],
                   w[27], w[26], w[25], w[24], w[17], w[16], w[15],
                   w[23:18], w[14:12], (c == 4'd15)};
            m_rem = int'(l) - 1;
            m_idx = 1;
            m_cls = c;
            m_len = l;
        end else begin
            exp = {1'b1, 1'b0, m_cls, m_len, 2'(m_idx), 12'd0, 7'd0, 9'd0, 1'b0};
            m_rem--;
            m_idx++;
        end
        i_valid = 1'b1; i_word = w; i_restart = rs;
        @(negedge clk);
        i_valid = 1'b0; i_restart = 1'b0;
        compare(exp, req);
    endtask

    task automatic idle(input int n, input bit rs);
        i_restart = rs;
        if (rs) m_rem = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            i_restart = 1'b0;
            compare(40'd0, "R8");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare(40'd0, "R1");
        // R1: first word after reset is an opcode, even with an argument-like pattern
        send(32'h1000_0040, 1'b0, "R1");
        send(32'h1234_5678, 1'b0, "R6");

        // R2 R5 R6 R7: sweep every code, arguments look like write opcodes
        for (int c = 0; c < 16; c++) begin
            logic [31:0] w;
            w = {4'(c), 16'h0000, 12'(c * 37 + 5)};
            send(w, 1'b0, "R2");
            while (m_rem > 0) send(32'h1C00_0000 | 32'(c * 3 + m_idx), 1'b0, "R6");
        end

        // R3: count extremes
        send(32'h8000_0FFF, 1'b0, "R3");
        send(32'h8000_0000, 1'b0, "R3");

        // R4: walk one bit across the flag field, on sync and on write opcodes
        for (int b = 12; b < 28; b++) begin
            send(32'h8000_0000 | (32'd1 << b) | 32'h0A5, 1'b0, "R4");
            send(32'h1000_0000 | (32'd1 << b), 1'b0, "R4");
            send(32'hD000_0000, 1'b0, "R6");
        end

        // R8: gaps inside a four-word instruction do not advance position
        send(32'hD800_0010, 1'b0, "R5");
        idle(2, 1'b0);
        send(32'h8000_0001, 1'b0, "R8");
        idle(3, 1'b0);
        send(32'h1000_0002, 1'b0, "R8");
        send(32'h2000_0003, 1'b0, "R8");
        send(32'hF000_0004, 1'b0, "R7");

        // R9: restart together with a word, mid instruction
        send(32'hB000_0020, 1'b0, "R5");
        send(32'hB000_0021, 1'b0, "R6");
        send(32'h9400_0022, 1'b1, "R9");
        // R9: restart alone, mid instruction
        send(32'hC000_0030, 1'b0, "R5");
        idle(1, 1'b1);
        send(32'h7000_0031, 1'b0, "R9");
        send(32'h8000_0032, 1'b0, "R9");
        // R9: restart on an opcode boundary keeps decoding normal
        send(32'h3000_0033, 1'b1, "R9");

        // R10: back-to-back single-word opcodes, one record per cycle
        for (int k = 0; k < 8; k++) send({4'h8, 16'(k * 4099), 12'(k)}, 1'b0, "R10");
        idle(2, 1'b0);

        // R1: reset in the middle of an instruction
        send(32'hD000_0000, 1'b0, "R5");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_rem = 0;
        compare(40'd0, "R1");
        send(32'h5000_0077, 1'b0, "R1");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule